// File: doc/BRIEF.md
# Timed-Access Unlock Guard

This block protects a small control register against stray writes. The register changes only after software has written a two-value key to one reserved register address, and then issues the protected write within a short window. The window and the key are both measured in machine cycles, which are marked by a one-clock `cyc_tick` enable. A runaway program is very unlikely to produce the right address, the right data order and the right timing all at once.

Three steps make up the sequence. A write of the arming value 0xAA to the key address arms the guard. A write of 0x55 to the same address, made while the guard is armed, opens it. The next protected write then loads the register and closes the window. Any slip in the order, address, data or timing sends the guard back to idle. A protected write made while the guard is not open is dropped.

Top module: `ta_unlock_guard`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) drives `access_open` to 0, `prot_q` to 0x00 and the key sequence to idle. After reset, a 0x55 key write alone does not open access.
- R2: A bus write of 0xAA to the key address 0xC7 arms the guard without opening it. A following bus write of 0x55 to 0xC7, made while armed, raises `access_open` after that clock edge.
- R3: Once open, `access_open` stays high until three `cyc_tick` pulses have been sampled after the opening edge, and falls on the edge that samples the third pulse. A tick sampled on the opening edge itself is not counted, and cycles without a tick do not shorten the window.
- R4: A `prot_wr` sampled while `access_open` is high loads `prot_wdata` into `prot_q` on that edge and closes the window. This includes the cycle of the third tick. A second protected write needs a new key sequence.
- R5: A `prot_wr` sampled while `access_open` is low leaves `prot_q` unchanged.
- R6: While armed, the guard returns to idle on the edge that samples the third `cyc_tick` after the 0xAA write. A 0x55 key write on that same edge still opens access. Cycles without a tick never end the armed state.
- R7: While armed, any bus write other than 0x55 to 0xC7 aborts the sequence to idle. This covers any data to another address, a repeated 0xAA, and any other value to 0xC7.
- R8: A 0x55 key write made while idle has no effect: access stays closed.
- R9: While open, bus writes of any address or data do not change the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-clock pulse marking a machine cycle |
| wr_en | input | 1 | Register bus write strobe |
| wr_addr | input | 8 | Register bus write address |
| wr_data | input | 8 | Register bus write data |
| prot_wr | input | 1 | Request to write the protected register |
| prot_wdata | input | 8 | Value for the protected register |
| access_open | output | 1 | High while a protected write would be accepted |
| prot_q | output | 8 | Protected register contents |

## Verification
On every cycle the assertions check four things. Access only opens on the edge after a 0x55 key write made while armed. The protected register holds unless a write lands during an open window. A granted write closes the window. Tick counters in the checker bound both the armed span and the open span, and check that an armed-state abort and an idle-state key write behave as required. The bench scenarios are needed for the end-to-end sequences: exact window lengths with and without idle gaps, the key write that lands on the last armed tick, writes ignored while open, and a reset in the middle of an open window.

// File: rtl/ta_guard_pkg.sv
package ta_guard_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_OPEN  = 2'd2
  } seq_state_e;

  // Width needed to hold the larger of two tick spans.
  function automatic int unsigned span_width(input int unsigned a,
                                             input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 1) ? 1 : $clog2(m + 1);
  endfunction

  // A span ends on the edge where a tick meets the last remaining unit.
  function automatic logic span_ends(input logic tick,
                                     input int unsigned remaining);
    return tick && (remaining == 1);
  endfunction

  // Remaining units after one edge.
  function automatic int unsigned span_next(input logic tick,
                                            input int unsigned remaining);
    return (tick && remaining != 0) ? remaining - 1 : remaining;
  endfunction

endpackage

// File: rtl/ta_bus_decode.sv
module ta_bus_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = ADDR_W'('hC7),
  parameter logic [DATA_W-1:0] KEY_FIRST  = DATA_W'('hAA),
  parameter logic [DATA_W-1:0] KEY_SECOND = DATA_W'('h55)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              first_hit,
  output logic              second_hit,
  output logic              other_write
);

  logic addr_match;

  always_comb begin
    addr_match  = (wr_addr == KEY_ADDR);
    first_hit   = wr_en && addr_match && (wr_data == KEY_FIRST);
    second_hit  = wr_en && addr_match && (wr_data == KEY_SECOND);
    other_write = wr_en && !second_hit;
  end

endmodule

// File: rtl/ta_tick_timer.sv
module ta_tick_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             last
);

  import ta_guard_pkg::*;

  logic [CNT_W-1:0] count_d;

  always_comb begin
    last = span_ends(tick, 32'(count));
    if (load)       count_d = load_val;
    else if (clear) count_d = '0;
    else            count_d = CNT_W'(span_next(tick, 32'(count)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

endmodule

// File: rtl/ta_seq_ctrl.sv
module ta_seq_ctrl #(
  parameter int unsigned ARM_TICKS  = 3,
  parameter int unsigned OPEN_TICKS = 3,
  parameter int unsigned CNT_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_hit,
  input  logic             second_hit,
  input  logic             other_write,
  input  logic             prot_wr,
  input  logic             cnt_last,
  output logic [1:0]       state_o,
  output logic             open_o,
  output logic             grant_o,
  output logic             abort_o,
  output logic             expire_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             clear_o
);

  import ta_guard_pkg::*;

  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    clear_o    = 1'b0;
    grant_o    = 1'b0;
    abort_o    = 1'b0;
    expire_o   = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (first_hit) begin
          state_d    = SEQ_ARMED;
          load_o     = 1'b1;
          load_val_o = CNT_W'(ARM_TICKS);
        end
      end
      SEQ_ARMED: begin
        if (second_hit) begin
          state_d    = SEQ_OPEN;
          load_o     = 1'b1;
          load_val_o = CNT_W'(OPEN_TICKS);
        end else if (other_write) begin
          state_d = SEQ_IDLE;
          clear_o = 1'b1;
          abort_o = 1'b1;
        end else if (cnt_last) begin
          state_d  = SEQ_IDLE;
          clear_o  = 1'b1;
          expire_o = 1'b1;
        end
      end
      SEQ_OPEN: begin
        if (prot_wr) begin
          state_d = SEQ_IDLE;
          clear_o = 1'b1;
          grant_o = 1'b1;
        end else if (cnt_last) begin
          state_d  = SEQ_IDLE;
          clear_o  = 1'b1;
          expire_o = 1'b1;
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        clear_o = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign open_o  = (state_q == SEQ_OPEN);

endmodule

// File: rtl/ta_prot_reg.sv
module ta_prot_reg #(
  parameter int unsigned PROT_W = 8,
  parameter logic [PROT_W-1:0] PROT_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PROT_W-1:0] d,
  output logic [PROT_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= PROT_INIT;
    else if (we) q <= d;
  end

endmodule

// File: rtl/ta_unlock_guard.sv
module ta_unlock_guard #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PROT_W     = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = ADDR_W'('hC7),
  parameter logic [DATA_W-1:0] KEY_FIRST  = DATA_W'('hAA),
  parameter logic [DATA_W-1:0] KEY_SECOND = DATA_W'('h55),
  parameter int unsigned ARM_TICKS  = 3,
  parameter int unsigned OPEN_TICKS = 3,
  parameter logic [PROT_W-1:0] PROT_INIT  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prot_wr,
  input  logic [PROT_W-1:0] prot_wdata,
  output logic              access_open,
  output logic [PROT_W-1:0] prot_q
);

  import ta_guard_pkg::*;

  localparam int unsigned CNT_W = span_width(ARM_TICKS, OPEN_TICKS);

  // Named internal events, visible to the bound checker.
  logic             first_hit, second_hit, other_write;
  logic             cnt_last, cnt_load, cnt_clear;
  logic [CNT_W-1:0] cnt_load_val, cnt_value;
  logic [1:0]       seq_state;
  logic             grant_evt, abort_evt, expire_evt;

  ta_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .first_hit(first_hit), .second_hit(second_hit), .other_write(other_write)
  );

  ta_tick_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_load_val),
    .clear(cnt_clear), .tick(cyc_tick), .count(cnt_value), .last(cnt_last)
  );

  ta_seq_ctrl #(
    .ARM_TICKS(ARM_TICKS), .OPEN_TICKS(OPEN_TICKS), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .first_hit(first_hit), .second_hit(second_hit),
    .other_write(other_write), .prot_wr(prot_wr), .cnt_last(cnt_last),
    .state_o(seq_state), .open_o(access_open), .grant_o(grant_evt),
    .abort_o(abort_evt), .expire_o(expire_evt), .load_o(cnt_load),
    .load_val_o(cnt_load_val), .clear_o(cnt_clear)
  );

  ta_prot_reg #(.PROT_W(PROT_W), .PROT_INIT(PROT_INIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(grant_evt), .d(prot_wdata), .q(prot_q)
  );

endmodule

// File: rtl/ta_unlock_guard_chk.sv
module ta_unlock_guard_chk #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PROT_W     = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = ADDR_W'('hC7),
  parameter logic [DATA_W-1:0] KEY_SECOND = DATA_W'('h55),
  parameter int unsigned ARM_TICKS  = 3,
  parameter int unsigned OPEN_TICKS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              prot_wr,
  input logic [PROT_W-1:0] prot_wdata,
  input logic              access_open,
  input logic [PROT_W-1:0] prot_q,
  input logic [1:0]        seq_state
);

  import ta_guard_pkg::*;

  int unsigned open_ticks, arm_ticks;
  logic key2_write;

  assign key2_write = wr_en && (wr_addr == KEY_ADDR) && (wr_data == KEY_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_ticks <= 0;
      arm_ticks  <= 0;
    end else begin
      open_ticks <= !access_open ? 0 : (cyc_tick ? open_ticks + 1 : open_ticks);
      arm_ticks  <= (seq_state != SEQ_ARMED) ? 0 :
                    (cyc_tick ? arm_ticks + 1 : arm_ticks);
    end
  end

  // R2
  open_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_open) |-> ($past(key2_write) && $past(seq_state) == SEQ_ARMED));

  // R3
  open_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_open |-> open_ticks < OPEN_TICKS);

  // R4
  consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access_open && prot_wr) |=> (!access_open && prot_q == $past(prot_wdata)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(access_open && prot_wr) |=> $stable(prot_q));

  // R6
  arm_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SEQ_ARMED) |-> arm_ticks < ARM_TICKS);

  // R7
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SEQ_ARMED && wr_en && !key2_write) |=> seq_state == SEQ_IDLE);

  // R8
  idle_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SEQ_IDLE) |=> !access_open);

  // R9
  open_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access_open && !prot_wr && !(cyc_tick && open_ticks + 1 == OPEN_TICKS))
      |=> access_open);

endmodule

bind ta_unlock_guard ta_unlock_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_W(PROT_W), .KEY_ADDR(KEY_ADDR),
  .KEY_SECOND(KEY_SECOND), .ARM_TICKS(ARM_TICKS), .OPEN_TICKS(OPEN_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .prot_wr(prot_wr),
  .prot_wdata(prot_wdata), .access_open(access_open), .prot_q(prot_q),
  .seq_state(seq_state)
);

// File: tb/ta_unlock_guard_tb_top.sv
module ta_unlock_guard_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] KEY   = 8'hC7;
  localparam logic [7:0] OTHER = 8'h80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       prot_wr = 1'b0;
  logic [7:0] prot_wdata = '0;
  logic       access_open;
  logic [7:0] prot_q;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic       open;
    logic [7:0] q;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ta_unlock_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .prot_wr(prot_wr),
    .prot_wdata(prot_wdata), .access_open(access_open), .prot_q(prot_q)
  );

  // Monitor: compares queued expectations half a period after the edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        tests++;
        if (access_open !== e.open || prot_q !== e.q) begin
          fails++;
          $display("FAIL %s: actual open=%0b q=%02h expected open=%0b q=%02h",
                   e.tag, access_open, prot_q, e.open, e.q);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog (R1..): actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic expect_out(input logic o, input logic [7:0] qv, input string tag);
    exp_t e;
    e.open = o;
    e.q    = qv;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // One clock with the given inputs; returns just after the edge.
  task automatic drive(input logic we, input logic [7:0] a, input logic [7:0] d,
                       input logic tk, input logic pw, input logic [7:0] pd);
    wr_en = we; wr_addr = a; wr_data = d;
    cyc_tick = tk; prot_wr = pw; prot_wdata = pd;
    @(posedge clk);
    #1;
    wr_en = 1'b0; cyc_tick = 1'b0; prot_wr = 1'b0;
  endtask

  task automatic bus(input logic [7:0] a, input logic [7:0] d, input logic tk);
    drive(1'b1, a, d, tk, 1'b0, 8'h00);
  endtask
  task automatic tick();
    drive(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00);
  endtask
  task automatic idle();
    drive(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00);
  endtask
  task automatic pwrite(input logic [7:0] d, input logic tk);
    drive(1'b0, 8'h00, 8'h00, tk, 1'b1, d);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_out(1'b0, 8'h00, "R1 reset state");
    rst_n = 1'b1;
    idle();

    // R2 / R4 / R5: basic unlock and consume
    bus(KEY, 8'hAA, 1'b0); expect_out(1'b0, 8'h00, "R2 armed not open");
    bus(KEY, 8'h55, 1'b0); expect_out(1'b1, 8'h00, "R2 open after second key");
    pwrite(8'h5A, 1'b0);   expect_out(1'b0, 8'h5A, "R4 write accepted, window closed");
    pwrite(8'hFF, 1'b0);   expect_out(1'b0, 8'h5A, "R5 write after consume ignored");

    // R3: window length
    bus(KEY, 8'hAA, 1'b0);
    bus(KEY, 8'h55, 1'b1); expect_out(1'b1, 8'h5A, "R3 tick on key edge not counted");
    repeat (4) idle();     expect_out(1'b1, 8'h5A, "R3 tickless cycles keep window");
    tick();                expect_out(1'b1, 8'h5A, "R3 open after first tick");
    tick();                expect_out(1'b1, 8'h5A, "R3 open after second tick");
    tick();                expect_out(1'b0, 8'h5A, "R3 closed on third tick");
    pwrite(8'h0F, 1'b0);   expect_out(1'b0, 8'h5A, "R5 write after expiry ignored");

    // R4: write during the third tick cycle
    bus(KEY, 8'hAA, 1'b0); bus(KEY, 8'h55, 1'b0); tick(); tick();
    pwrite(8'h33, 1'b1);   expect_out(1'b0, 8'h33, "R4 write on third tick accepted");

    // R6: armed span
    bus(KEY, 8'hAA, 1'b0); tick(); tick();
    bus(KEY, 8'h55, 1'b1); expect_out(1'b1, 8'h33, "R6 second key on last armed tick");
    pwrite(8'h11, 1'b0);   expect_out(1'b0, 8'h11, "R4 write after late key");
    bus(KEY, 8'hAA, 1'b0); tick(); tick(); tick();
    bus(KEY, 8'h55, 1'b0); expect_out(1'b0, 8'h11, "R6 armed span expired");
    pwrite(8'h22, 1'b0);   expect_out(1'b0, 8'h11, "R5 write after failed unlock");
    bus(KEY, 8'hAA, 1'b0); repeat (3) idle();
    bus(KEY, 8'h55, 1'b0); expect_out(1'b1, 8'h11, "R6 tickless cycles keep armed");
    pwrite(8'h66, 1'b0);   expect_out(1'b0, 8'h66, "R4 write after tickless arm");

    // R7: aborts while armed
    bus(KEY, 8'hAA, 1'b0); bus(OTHER, 8'h55, 1'b0);
    bus(KEY, 8'h55, 1'b0); expect_out(1'b0, 8'h66, "R7 other address aborts");
    bus(KEY, 8'hAA, 1'b0); bus(KEY, 8'hAA, 1'b0);
    bus(KEY, 8'h55, 1'b0); expect_out(1'b0, 8'h66, "R7 repeated first key aborts");
    bus(KEY, 8'hAA, 1'b0); bus(KEY, 8'h12, 1'b0);
    bus(KEY, 8'h55, 1'b0); expect_out(1'b0, 8'h66, "R7 wrong data aborts");
    pwrite(8'h44, 1'b0);   expect_out(1'b0, 8'h66, "R7 register kept after aborts");

    // R8: second key alone
    bus(KEY, 8'h55, 1'b0); expect_out(1'b0, 8'h66, "R8 second key from idle");
    pwrite(8'h99, 1'b0);   expect_out(1'b0, 8'h66, "R8 register kept");

    // R9: bus writes while open
    bus(KEY, 8'hAA, 1'b0); bus(KEY, 8'h55, 1'b0);
    bus(OTHER, 8'hAB, 1'b0); bus(KEY, 8'hAA, 1'b0); bus(KEY, 8'h12, 1'b0);
    expect_out(1'b1, 8'h66, "R9 bus writes leave window open");
    pwrite(8'h77, 1'b0);   expect_out(1'b0, 8'h77, "R9 write still accepted");

    // R1: reset in the middle of an open window
    bus(KEY, 8'hAA, 1'b0); bus(KEY, 8'h55, 1'b0);
    rst_n = 1'b0;
    @(posedge clk); #1;
    expect_out(1'b0, 8'h00, "R1 reset clears window and register");
    rst_n = 1'b1;
    bus(KEY, 8'h55, 1'b0); expect_out(1'b0, 8'h00, "R1 unlock state cleared");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule